// File: doc/BRIEF.md
# DRAM Low-Power Entry and Exit Sequencer

This block sits next to a DRAM command scheduler and decides when the device may drop into a low-power state and when it must come back. An idle-timeout indication from the scheduler asks for sleep. A select input picks the target: power-down, or self-refresh. In power-down the block chooses active power-down when any row is open and precharge power-down when every row is closed. Before entering self-refresh with rows open, it first issues a precharge-all and waits out the precharge busy time.

The block tracks the kind of the last command the scheduler issued. After a read or a write it holds off entry until the data burst, and any write recovery, is finished. Once the device is in a low-power state, the block keeps it there for the minimum residency of that state. A wake request, or a wake for a pending refresh, then produces the matching exit command. A wake that comes early is remembered until residency expires. While the device is asleep or leaving sleep, the grant that permits normal commands is withdrawn.

Top module: `dram_lowpower_ctrl`

## Requirements
- R1: After a read (kind 1) or read with auto-precharge (kind 2), the first entry command appears no earlier than T_RL + BURST_LEN/DATA_RATE + 1 cycles after the cycle that reported the read. With the timeout already held, it appears exactly that many cycles later plus one output register cycle.
- R2: After a write (kind 3), entry waits T_WL + BURST_LEN/DATA_RATE + T_WR cycles. After a write with auto-precharge (kind 4), it waits one cycle more. Every other kind (0, 5..7) waits one cycle.
- R3: With no recent command, an idle timeout sampled at a clock edge yields the entry command on `lp_cmd` in the following cycle, with `lp_cmd_valid` high for exactly one cycle.
- R4: When the power-down target is selected (`sref_sel`=0), the entry code is 2 (active power-down) if any row is open and 3 (precharge power-down) if all rows are closed. When self-refresh is selected and all rows are closed, the entry code is 4.
- R5: When self-refresh is selected and a row is open, the block first issues precharge-all (code 1). It then issues the self-refresh entry (code 4) exactly T_RP cycles later.
- R6: Active and precharge power-down last at least T_CKE cycles from entry to exit. With wake held from entry, the exit comes exactly T_CKE cycles after entry.
- R7: Self-refresh lasts at least T_CKESR cycles. With wake held from entry, the exit comes exactly T_CKESR cycles after entry.
- R8: Each exit code matches its state: 5 leaves active power-down, 6 leaves precharge power-down, 7 leaves self-refresh. A wake raised after residency has expired gives the exit in the next cycle.
- R9: A single-cycle wake pulse during residency is held. The exit still appears when residency expires.
- R10: A refresh wake request during a low-power state causes the same exit as a normal wake.
- R11: `grant_ok` is low from the cycle of any entry or precharge-all command through the cycle of the exit command. It is high again in the cycle after the exit.
- R12: A wake during the precharge-all busy time cancels self-refresh entry. No entry or exit command is issued, and `grant_ok` returns T_RP cycles after the precharge-all.
- R13: While awake, an active wake or refresh wake request blocks entry even when the idle timeout is present.
- R14: After reset, no command is issued and `grant_ok` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idle_timeout | input | 1 | Scheduler idle, low-power entry wanted |
| sref_sel | input | 1 | 1: timeout targets self-refresh, 0: power-down |
| wake_req | input | 1 | Request to leave, or not enter, low power |
| ref_wake_req | input | 1 | Refresh pending, wake needed |
| any_row_open | input | 1 | At least one bank has an open row |
| last_cmd_valid | input | 1 | Scheduler issued a command this cycle |
| last_cmd_kind | input | 3 | Kind of that command: 0 other, 1 read, 2 read+AP, 3 write, 4 write+AP |
| lp_cmd_valid | output | 1 | A low-power command is issued this cycle |
| lp_cmd | output | 3 | 1 precharge-all, 2/3/4 enter APD/PPD/SREF, 5/6/7 exit APD/PPD/SREF |
| grant_ok | output | 1 | Normal commands may be issued |

## Verification
A wrong state register shows up as a wrong entry or exit code, or as `grant_ok` out of step with the commands, no later than the next command the block issues. A miscounting spacing or residency timer shifts the cycle of the entry or exit command. The bench measures that cycle exactly against the arithmetic limit for each last-command kind and each state, so an off-by-one shows within one sleep cycle. A lost pending wake leaves the device asleep, and the watchdog or the exit-distance check reports it.

// File: rtl/lp_pkg.sv
// Package: shared encodings for the low-power sequencer.
// Assumes 3-bit command kind and low-power command codes as listed in the brief.
package lp_pkg;

    typedef enum logic [2:0] {
        LK_OTHER = 3'd0,
        LK_RD    = 3'd1,
        LK_RDA   = 3'd2,
        LK_WR    = 3'd3,
        LK_WRA   = 3'd4
    } last_kind_e;

    typedef enum logic [2:0] {
        LC_NONE  = 3'd0,
        LC_PREA  = 3'd1,
        LC_EAPD  = 3'd2,
        LC_EPPD  = 3'd3,
        LC_ESREF = 3'd4,
        LC_XAPD  = 3'd5,
        LC_XPPD  = 3'd6,
        LC_XSREF = 3'd7
    } lp_cmd_e;

    typedef enum logic [2:0] {
        ST_AWAKE   = 3'd0,
        ST_PRE_ALL = 3'd1,
        ST_PDN_ACT = 3'd2,
        ST_PDN_PRE = 3'd3,
        ST_SREF    = 3'd4,
        ST_EXIT    = 3'd5
    } lp_state_e;

    function automatic int lp_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lp_gap_timer.sv
// Module: lp_gap_timer
// Counts the spacing required after the last read or write before a
// low-power entry may be issued. Assumes every gap is at least one cycle.
module lp_gap_timer
    import lp_pkg::*;
#(
    parameter int T_RL      = 5,
    parameter int T_WL      = 4,
    parameter int T_WR      = 6,
    parameter int BURST_LEN = 8,
    parameter int DATA_RATE = 2,
    parameter int W         = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       last_valid,
    input  logic [2:0] last_kind,
    output logic       gap_ok
);
    localparam int BURST_CYC = (DATA_RATE == 1) ? BURST_LEN : BURST_LEN / DATA_RATE;
    localparam int GAP_RD    = T_RL + BURST_CYC + 1;
    localparam int GAP_WR    = T_WL + BURST_CYC + T_WR;
    localparam int GAP_WRA   = GAP_WR + 1;
    localparam int GAP_OTH   = 1;

    logic [W-1:0] cnt;
    logic [W-1:0] need_m1;

    // Select the reload value (gap minus one) from the last command kind.
    always_comb begin
        case (last_kind_e'(last_kind))
            LK_RD, LK_RDA: need_m1 = W'(GAP_RD - 1);
            LK_WR:         need_m1 = W'(GAP_WR - 1);
            LK_WRA:        need_m1 = W'(GAP_WRA - 1);
            default:       need_m1 = W'(GAP_OTH - 1);
        endcase
    end

    // Reload on every reported command, count down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (last_valid)
            cnt <= need_m1;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign gap_ok = (cnt == '0) && !last_valid;

    // R1: a read blocks entry in the following cycle
    a_r1_read_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (last_valid && (last_kind == LK_RD || last_kind == LK_RDA)) |=> !gap_ok);
    // R2: a write blocks entry in the following cycle
    a_r2_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (last_valid && (last_kind == LK_WR || last_kind == LK_WRA)) |=> !gap_ok);
endmodule

// File: rtl/lp_dwell_timer.sv
// Module: lp_dwell_timer
// Down-counter for residency and precharge busy time. A load of N-1
// makes done true N cycles after the loading edge. Assumes N >= 1.
module lp_dwell_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    // Load on request, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R6: once expired, the timer stays expired until reloaded
    a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done);
endmodule

// File: rtl/lp_fsm.sv
// Module: lp_fsm
// Low-power state machine: picks the entry command, holds early wakes,
// issues the matching exit and gates the normal command grant.
// Assumes the residency and busy timers are loaded through res_load/res_val.
module lp_fsm
    import lp_pkg::*;
#(
    parameter int T_RP    = 5,
    parameter int T_CKE   = 3,
    parameter int T_CKESR = 5,
    parameter int W       = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sleep_req,
    input  logic         sref_sel,
    input  logic         wake_req,
    input  logic         ref_wake_req,
    input  logic         row_open,
    input  logic         gap_ok,
    input  logic         res_done,
    output logic         res_load,
    output logic [W-1:0] res_val,
    output logic         cmd_valid,
    output logic [2:0]   cmd_code,
    output logic         grant_ok
);
    localparam int DW = W + 1;

    lp_state_e state, nxt;
    lp_cmd_e   cmd_q, cmd_nxt;
    logic      wake_pend;
    logic      wake_any;
    logic      in_sleep;
    logic [DW-1:0] dwell;
    lp_cmd_e   ent_code;

    assign in_sleep = (state == ST_PDN_ACT) || (state == ST_PDN_PRE) || (state == ST_SREF);
    assign wake_any = wake_req || ref_wake_req || wake_pend;

    // Next-state, command and timer-load decision.
    always_comb begin
        nxt      = state;
        cmd_nxt  = LC_NONE;
        res_load = 1'b0;
        res_val  = '0;
        case (state)
            ST_AWAKE: begin
                if (sleep_req && gap_ok && !wake_req && !ref_wake_req) begin
                    res_load = 1'b1;
                    if (sref_sel && row_open) begin
                        nxt     = ST_PRE_ALL;
                        cmd_nxt = LC_PREA;
                        res_val = W'(T_RP - 1);
                    end else if (sref_sel) begin
                        nxt     = ST_SREF;
                        cmd_nxt = LC_ESREF;
                        res_val = W'(T_CKESR - 1);
                    end else if (row_open) begin
                        nxt     = ST_PDN_ACT;
                        cmd_nxt = LC_EAPD;
                        res_val = W'(T_CKE - 1);
                    end else begin
                        nxt     = ST_PDN_PRE;
                        cmd_nxt = LC_EPPD;
                        res_val = W'(T_CKE - 1);
                    end
                end
            end
            ST_PRE_ALL: begin
                if (res_done) begin
                    if (wake_any) begin
                        nxt = ST_AWAKE;
                    end else begin
                        nxt      = ST_SREF;
                        cmd_nxt  = LC_ESREF;
                        res_load = 1'b1;
                        res_val  = W'(T_CKESR - 1);
                    end
                end
            end
            ST_PDN_ACT: begin
                if (res_done && wake_any) begin
                    nxt     = ST_EXIT;
                    cmd_nxt = LC_XAPD;
                end
            end
            ST_PDN_PRE: begin
                if (res_done && wake_any) begin
                    nxt     = ST_EXIT;
                    cmd_nxt = LC_XPPD;
                end
            end
            ST_SREF: begin
                if (res_done && wake_any) begin
                    nxt     = ST_EXIT;
                    cmd_nxt = LC_XSREF;
                end
            end
            default: nxt = ST_AWAKE;
        endcase
    end

    // State and registered command output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_AWAKE;
            cmd_q <= LC_NONE;
        end else begin
            state <= nxt;
            cmd_q <= cmd_nxt;
        end
    end

    // Remember a wake seen while asleep or precharging until it is served.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wake_pend <= 1'b0;
        else if (nxt == ST_EXIT || nxt == ST_AWAKE)
            wake_pend <= 1'b0;
        else if ((in_sleep || state == ST_PRE_ALL) && (wake_req || ref_wake_req))
            wake_pend <= 1'b1;
    end

    // Cycles since the last entry command, and which entry it was (checking aid).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dwell    <= '0;
            ent_code <= LC_NONE;
        end else if (cmd_nxt == LC_EAPD || cmd_nxt == LC_EPPD || cmd_nxt == LC_ESREF) begin
            dwell    <= '0;
            ent_code <= cmd_nxt;
        end else if (dwell != '1) begin
            dwell <= dwell + 1'b1;
        end
    end

    assign cmd_valid = (cmd_q != LC_NONE);
    assign cmd_code  = cmd_q;
    assign grant_ok  = (state == ST_AWAKE);

    // R6: power-down exit only after T_CKE cycles of residency
    a_r6_cke_residency: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_code == LC_XAPD || cmd_code == LC_XPPD)) |-> (dwell >= DW'(T_CKE)));
    // R7: self-refresh exit only after T_CKESR cycles of residency
    a_r7_sref_residency: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == LC_XSREF) |-> (dwell >= DW'(T_CKESR)));
    // R8: exit code matches the state that was entered
    a_r8_exit_match: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code >= LC_XAPD) |-> (cmd_code == 3'(ent_code + 3'd3)));
    // R11: every low-power command is issued with the grant withdrawn
    a_r11_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !grant_ok);
    // R11: the grant returns the cycle after an exit command
    a_r11_grant_back: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code >= LC_XAPD) |=> grant_ok);
    // R5: precharge-all only when a row was open
    a_r5_prea_row: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == LC_PREA) |-> $past(row_open));
endmodule

// File: rtl/dram_lowpower_ctrl.sv
// Module: dram_lowpower_ctrl (top)
// Joins the entry spacing timer, the residency timer and the state machine.
// Assumes timing parameters are in clock cycles and each is at least 1.
module dram_lowpower_ctrl
    import lp_pkg::*;
#(
    parameter int T_RL      = 5,
    parameter int T_WL      = 4,
    parameter int T_WR      = 6,
    parameter int BURST_LEN = 8,
    parameter int DATA_RATE = 2,
    parameter int T_RP      = 5,
    parameter int T_CKE     = 3,
    parameter int T_CKESR   = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idle_timeout,
    input  logic       sref_sel,
    input  logic       wake_req,
    input  logic       ref_wake_req,
    input  logic       any_row_open,
    input  logic       last_cmd_valid,
    input  logic [2:0] last_cmd_kind,
    output logic       lp_cmd_valid,
    output logic [2:0] lp_cmd,
    output logic       grant_ok
);
    localparam int BURST_CYC = (DATA_RATE == 1) ? BURST_LEN : BURST_LEN / DATA_RATE;
    localparam int GAP_MAX   = lp_max(T_WL + BURST_CYC + T_WR + 1, T_RL + BURST_CYC + 1);
    localparam int TMR_MAX   = lp_max(T_RP, lp_max(T_CKE, T_CKESR));
    localparam int W         = $clog2(lp_max(GAP_MAX, TMR_MAX) + 1);

    logic         gap_ok;
    logic         res_done;
    logic         res_load;
    logic [W-1:0] res_val;

    lp_gap_timer #(
        .T_RL(T_RL), .T_WL(T_WL), .T_WR(T_WR),
        .BURST_LEN(BURST_LEN), .DATA_RATE(DATA_RATE), .W(W)
    ) i_gap (
        .clk(clk), .rst_n(rst_n),
        .last_valid(last_cmd_valid), .last_kind(last_cmd_kind),
        .gap_ok(gap_ok)
    );

    lp_dwell_timer #(.W(W)) i_dwell (
        .clk(clk), .rst_n(rst_n),
        .load(res_load), .load_val(res_val), .done(res_done)
    );

    lp_fsm #(
        .T_RP(T_RP), .T_CKE(T_CKE), .T_CKESR(T_CKESR), .W(W)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n),
        .sleep_req(idle_timeout), .sref_sel(sref_sel),
        .wake_req(wake_req), .ref_wake_req(ref_wake_req),
        .row_open(any_row_open), .gap_ok(gap_ok), .res_done(res_done),
        .res_load(res_load), .res_val(res_val),
        .cmd_valid(lp_cmd_valid), .cmd_code(lp_cmd), .grant_ok(grant_ok)
    );

    // R1: an entry or precharge-all follows a cycle where spacing was met
    a_r1_gap_respected: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_cmd_valid && lp_cmd >= LC_PREA && lp_cmd <= LC_EPPD) |-> $past(gap_ok));
    // R13: no entry decision while a wake is requested
    a_r13_wake_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_ok && (wake_req || ref_wake_req)) |=> grant_ok);
endmodule

// File: tb/test_dram_lowpower_ctrl.sv
module test_dram_lowpower_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int T_RL = 5, T_WL = 4, T_WR = 6, BL = 8, DR = 2;
    localparam int T_RP = 5, T_CKE = 3, T_CKESR = 5;
    localparam int BC = BL / DR;

    logic clk = 0, rst_n = 0;
    logic idle_timeout = 0, sref_sel = 0, wake_req = 0, ref_wake_req = 0;
    logic any_row_open = 0, last_cmd_valid = 0;
    logic [2:0] last_cmd_kind = 0;
    logic lp_cmd_valid, grant_ok;
    logic [2:0] lp_cmd;
    int total = 0, bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_lowpower_ctrl i_dram_lowpower_ctrl (
        .clk(clk), .rst_n(rst_n), .idle_timeout(idle_timeout), .sref_sel(sref_sel),
        .wake_req(wake_req), .ref_wake_req(ref_wake_req), .any_row_open(any_row_open),
        .last_cmd_valid(last_cmd_valid), .last_cmd_kind(last_cmd_kind),
        .lp_cmd_valid(lp_cmd_valid), .lp_cmd(lp_cmd), .grant_ok(grant_ok));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Wait for next command; n = negedges elapsed.
    task automatic wait_cmd(output int n, output int code);
        n = 0; code = 0;
        do begin
            @(negedge clk); n++;
        end while (!lp_cmd_valid && n < 80);
        code = lp_cmd;
    endtask

    // Bring the block out of low power and back to awake.
    task automatic leave();
        int n, c;
        wake_req = 1;
        wait_cmd(n, c);
        wake_req = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic int gap_of(input int k);
        case (k)
            1, 2: return T_RL + BC + 1;
            3:    return T_WL + BC + T_WR;
            4:    return T_WL + BC + T_WR + 1;
            default: return 1;
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n, c;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R14: reset state
        chk(!lp_cmd_valid, "R14 cmd after reset", lp_cmd_valid, 0);
        chk(grant_ok, "R14 grant after reset", grant_ok, 1);

        // R1 R2 R3: spacing sweep over every command kind
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            last_cmd_valid = 1; last_cmd_kind = 3'(k); idle_timeout = 1;
            n = 0;
            do begin
                @(negedge clk); n++;
                if (n == 1) last_cmd_valid = 0;
            end while (!lp_cmd_valid && n < 80);
            idle_timeout = 0;
            chk(n == gap_of(k) + 1, (k == 1 || k == 2) ? "R1 read gap" : "R2 write/other gap",
                n, gap_of(k) + 1);
            chk(lp_cmd == 3, "R4 PPD code after gap", lp_cmd, 3);
            leave();
        end

        // R3 R4 R5 R6 R7 R8 R11: mode and row sweep
        for (int s = 0; s < 2; s++) begin
            for (int r = 0; r < 2; r++) begin
                int ent, expn;
                sref_sel = s[0]; any_row_open = r[0];
                idle_timeout = 1;
                wait_cmd(n, c);
                chk(n == 1, "R3 entry one cycle after timeout", n, 1);
                chk(grant_ok == 0, "R11 grant low at entry", grant_ok, 0);
                if (s == 1 && r == 1) begin
                    chk(c == 1, "R5 precharge-all first", c, 1);
                    wait_cmd(n, c);
                    chk(n == T_RP, "R5 sref after T_RP", n, T_RP);
                end
                ent = (s == 1) ? 4 : (r == 1 ? 2 : 3);
                chk(c == ent, "R4 entry code", c, ent);
                idle_timeout = 0; wake_req = 1;
                wait_cmd(n, c);
                expn = (s == 1) ? T_CKESR : T_CKE;
                chk(n == expn, (s == 1) ? "R7 sref residency" : "R6 pd residency", n, expn);
                chk(c == ent + 3, "R8 exit code", c, ent + 3);
                chk(grant_ok == 0, "R11 grant low at exit", grant_ok, 0);
                wake_req = 0;
                @(negedge clk);
                chk(grant_ok == 1, "R11 grant back after exit", grant_ok, 1);
            end
        end

        // R8: late wake gives exit next cycle
        sref_sel = 0; any_row_open = 0; idle_timeout = 1;
        wait_cmd(n, c);
        idle_timeout = 0;
        repeat (10) @(negedge clk);
        chk(!lp_cmd_valid && !grant_ok, "R8 stays asleep without wake", lp_cmd_valid, 0);
        wake_req = 1;
        wait_cmd(n, c);
        wake_req = 0;
        chk(n == 1 && c == 6, "R8 late wake exit", n * 10 + c, 16);
        @(negedge clk);

        // R9: wake pulse during self-refresh residency is held
        sref_sel = 1; any_row_open = 0; idle_timeout = 1;
        wait_cmd(n, c);
        idle_timeout = 0; wake_req = 1;
        n = 0;
        do begin
            @(negedge clk); n++;
            if (n == 1) wake_req = 0;
        end while (!lp_cmd_valid && n < 80);
        chk(n == T_CKESR && lp_cmd == 7, "R9 held wake exit", n, T_CKESR);
        @(negedge clk);

        // R10: refresh wake leaves active power-down
        sref_sel = 0; any_row_open = 1; idle_timeout = 1;
        wait_cmd(n, c);
        idle_timeout = 0; ref_wake_req = 1;
        wait_cmd(n, c);
        ref_wake_req = 0;
        chk(n == T_CKE && c == 5, "R10 refresh wake exit", n * 10 + c, T_CKE * 10 + 5);
        @(negedge clk);

        // R12: wake during precharge-all cancels self-refresh
        sref_sel = 1; any_row_open = 1; idle_timeout = 1;
        wait_cmd(n, c);
        chk(c == 1, "R12 precharge-all issued", c, 1);
        idle_timeout = 0; wake_req = 1;
        for (int i = 1; i <= T_RP + 3; i++) begin
            @(negedge clk);
            chk(!lp_cmd_valid, "R12 no command after cancel", lp_cmd, 0);
            if (i == T_RP - 1) chk(!grant_ok, "R12 grant low while busy", grant_ok, 0);
            if (i == T_RP) chk(grant_ok, "R12 grant back after T_RP", grant_ok, 1);
        end
        wake_req = 0;

        // R13: wake requests block entry while awake
        sref_sel = 0; any_row_open = 0; idle_timeout = 1; wake_req = 1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(!lp_cmd_valid && grant_ok, "R13 wake blocks entry", lp_cmd_valid, 0);
        end
        wake_req = 0; ref_wake_req = 1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(!lp_cmd_valid && grant_ok, "R13 refresh wake blocks entry", lp_cmd_valid, 0);
        end
        ref_wake_req = 0;
        wait_cmd(n, c);
        idle_timeout = 0;
        chk(n == 1 && c == 3, "R13 entry once released", n * 10 + c, 13);
        leave();

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule